// File: doc/BRIEF.md
# Even-Ratio Glitch-Free Clock Divider

This block derives a slow clock from a fast reference by an even integer ratio fixed at build time. With the default ratio of 200, a 200 MHz reference yields a 1 MHz output with a duty cycle of exactly one half. Internally, a cycle counter runs across one half-period of the output. Each time the counter reaches its last value, it flags a single toggle flip-flop, and the output flips.

The output pin is wired straight to the toggle flip-flop, with no gate in between. Any gate after the register could produce a runt pulse while its inputs settle, and such a pulse would act as a false edge for any logic clocked by the output. Reset is asynchronous and active-low. It returns the divider to a known phase, so the first output rising edge falls a fixed number of reference cycles after reset is released.

Top module: `clk_div_even`

## Requirements
- R1: While rst_ni is low, clk_o is 0 and the cycle counter is 0. Asserting rst_ni forces clk_o to 0 at once, without waiting for a clock edge.
- R2: The cycle counter steps through 0 to DIV_RATIO/2-1 on successive rising edges of clk_i. It returns to 0 on the edge that follows its last value.
- R3: clk_o inverts on exactly the rising edges of clk_i at which the counter holds DIV_RATIO/2-1. On every other edge it keeps its value.
- R4: Each high phase and each low phase of clk_o lasts exactly DIV_RATIO/2 cycles of clk_i. The period is therefore DIV_RATIO cycles with a 50% duty cycle.
- R5: Count the first rising edge of clk_i after rst_ni goes high as edge 1. clk_o first goes high just after edge DIV_RATIO/2, which is edge 100 with the default ratio.
- R6: clk_o comes directly from a flip-flop. It changes only just after a rising edge of clk_i and never between edges.
- R7: DIV_RATIO is even and at least 2. The default of 200 turns a 200 MHz reference into 1 MHz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_o | output | 1 | Divided clock, taken directly from the toggle flip-flop |

## Verification
The bench builds two copies of the divider from the same reference clock. One uses the default ratio of 200. The other uses a ratio of 6, which brings the counter wrap and the half-period boundaries within a few cycles, so many full periods fit into the run. Both copies are checked for the delay to the first rising edge after reset, the length of each high and low phase, and stability between reference edges. A reset is also applied in the middle of a high phase to show that the output drops at once and the phase restarts.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;

  // Counter width for a half-period length; at least one bit.
  function automatic int unsigned half_cnt_w(input int unsigned half);
    return (half <= 2) ? 1 : $clog2(half);
  endfunction

endpackage

// File: rtl/clk_div_cycle_cnt.sv
module clk_div_cycle_cnt
  import clk_div_pkg::*;
#(
  parameter int unsigned HALF = 100,
  localparam int unsigned W = half_cnt_w(HALF)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic last_o
);

  localparam logic [W-1:0] LastVal = W'(HALF - 1);

  logic [W-1:0] cnt_q;

  assign last_o = (cnt_q == LastVal);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (last_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + W'(1);
  end

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LastVal);

  p_cnt_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LastVal) |=> (cnt_q == '0));

  p_cnt_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != LastVal) |=> (cnt_q == $past(cnt_q) + W'(1)));

endmodule

// File: rtl/clk_div_toggle_reg.sv
module clk_div_toggle_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flip_i,
  output logic q_o
);

  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= 1'b0;
    else if (flip_i) q_q <= ~q_q;
  end

  // Register output with no logic after it.
  assign q_o = q_q;

  p_flip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flip_i |=> (q_o != $past(q_o)));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flip_i |=> $stable(q_o));

endmodule

// File: rtl/clk_div_even.sv
module clk_div_even #(
  parameter int unsigned DIV_RATIO = 200,
  localparam int unsigned HALF = DIV_RATIO / 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic clk_o
);

  initial begin
    p_ratio_even_r7: assert ((DIV_RATIO % 2) == 0 && DIV_RATIO >= 2);
  end

  logic half_done;

  clk_div_cycle_cnt #(.HALF(HALF)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .last_o (half_done)
  );

  clk_div_toggle_reg u_tgl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flip_i (half_done),
    .q_o    (clk_o)
  );

  p_out_only_on_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_o != $past(clk_o)) |-> $past(half_done));

  p_reset_low_r1: assert property (@(posedge clk_i) !rst_ni |-> !clk_o);

endmodule

// File: tb/clk_div_even_tb.sv
module clk_div_even_tb;

  localparam int unsigned RatioA = 200;
  localparam int unsigned RatioB = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic clk_a, clk_b;
  int   n_chk = 0;
  int   n_fail = 0;

  always #10 clk_i = ~clk_i;

  clk_div_even #(.DIV_RATIO(RatioA)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clk_o(clk_a)
  );
  clk_div_even #(.DIV_RATIO(RatioB)) u_dut_small (
    .clk_i(clk_i), .rst_ni(rst_ni), .clk_o(clk_b)
  );

  function automatic logic get_out(input bit sel);
    return sel ? clk_b : clk_a;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Cycles until output leaves level, also checking stability inside each cycle (R6).
  task automatic run_len(input bit sel, input logic level, output int len);
    logic a, b;
    len = 0;
    do begin
      @(posedge clk_i); #1;
      a = get_out(sel);
      len++;
      @(negedge clk_i); b = get_out(sel);
      if (a != b) check("R6 mid-cycle change", int'(b), int'(a));
      #9; if (get_out(sel) != b) check("R6 pre-edge change", int'(get_out(sel)), int'(b));
    end while (a == level && len < 1000);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R1 clk_o low in reset (ratio 200)", int'(clk_a), 0);
    check("R1 clk_o low in reset (ratio 6)", int'(clk_b), 0);
  endtask

  // Release reset at a negedge and count edges to first rise.
  task automatic t_first_rise(input bit sel, input int half);
    int n;
    @(negedge clk_i); rst_ni = 1'b1;
    run_len(sel, 1'b0, n);
    check(sel ? "R5 first rise ratio 6" : "R5 first rise ratio 200", n, half);
  endtask

  task automatic t_periods(input bit sel, input int half, input int reps);
    int hi, lo;
    for (int i = 0; i < reps; i++) begin
      run_len(sel, 1'b1, hi);
      run_len(sel, 1'b0, lo);
      check("R4 high phase length", hi, half);
      check("R4 low phase length", lo, half);
      check("R3 R2 period", hi + lo, 2 * half);
    end
  endtask

  task automatic t_mid_reset();
    int n;
    // In a high phase of the ratio-200 output.
    repeat (20) @(posedge clk_i);
    #3;
    check("R1 precondition high", int'(clk_a), 1);
    rst_ni = 1'b0;
    #1;
    check("R1 async drop ratio 200", int'(clk_a), 0);
    check("R1 async drop ratio 6", int'(clk_b), 0);
    repeat (2) @(posedge clk_i);
    t_first_rise(1'b0, RatioA / 2);
  endtask

  initial begin
    #(200000 * 20);
    check("watchdog", 1, 0);
    report();
  end

  initial begin
    t_reset();
    t_first_rise(1'b1, RatioB / 2);
    t_periods(1'b1, RatioB / 2, 6);
    t_reset();
    t_first_rise(1'b0, RatioA / 2);
    t_periods(1'b0, RatioA / 2, 2);
    t_mid_reset();
    report();
  end

endmodule